// File: doc/BRIEF.md
# Recirculating Echo Delay Line

This block adds a repeating echo to an audio sample stream, and sits after the amplitude-envelope stage of a synthesizer voice. Each incoming sample is added to a copy of an earlier output, scaled by a feedback gain. That sum is both sent downstream and written back into a circular buffer, so each echo returns again, quieter each time. The buffer is a dual-port memory. One port reads the delayed value and the other port stores the new sum.

Two small saturating parameter registers hold the echo spacing (in samples) and the feedback gain. A control strobe can load, increment or decrement either register. The gain register cannot hold a value above 0.9375. Because of this ceiling, the loop gain stays below one and the echo tail always dies away instead of building up to full scale. The samples arrive as strobes spaced well apart, at the audio rate, on a much faster clock.

Top module: `echo_delay_line`

## Requirements
- R1: After reset, `out_valid` is 0, `out_sample` is 0, the delay register reads 1 and the gain register reads 0.
- R2: For each cycle in which `in_valid` is sampled high, `out_valid` is high for exactly one cycle, two clock edges later. It is low in the cycle between.
- R3: The output is y = sat16(x + floor(g·d / 2^15)), where x is the input sample, d is the delayed sample and g is the gain register read as unsigned Q0.15.
- R4: For input sample number n (counted from 0 after reset) with delay D in force, d is the output produced for sample n−D. If n < D, d is zero.
- R5: The sum saturates to the range −32768..32767 before it is output and before it is stored in the buffer.
- R6: The gain register never exceeds 0x7800 (0.9375). A load of a larger value stores 0x7800, and an increment at the ceiling leaves it there.
- R7: Control encoding: `ctl_sel` 0 selects delay and 1 selects gain. `ctl_op` 0 holds, 1 loads `ctl_data`, 2 increments and 3 decrements. The delay step is 1 and the gain step is 0x0400. Delay stays within 1..255 and gain within 0..0x7800. A load outside the range stores the nearest limit, and a decrement at the minimum holds.
- R8: A new delay applies from the next sample on and does not clear the buffer. Later echoes are taken from outputs that were stored before the change.
- R9: With the gain at 0, each output equals its input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe, one cycle per sample |
| in_sample | input | 16 | Signed input sample |
| ctl_en | input | 1 | Control operation strobe |
| ctl_sel | input | 1 | Register select: 0 delay, 1 gain |
| ctl_op | input | 2 | 0 hold, 1 load, 2 increment, 3 decrement |
| ctl_data | input | 16 | Load value |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 16 | Signed echo output |
| cur_delay | output | 8 | Current delay in samples |
| cur_gain | output | 16 | Current feedback gain, unsigned Q0.15 |

## Verification
The assertions assume that sample strobes never occur on two adjacent cycles. The buffer write for one sample must land before the read for the next, and no forwarding path exists. To meet this, the driver holds at least two idle cycles between samples. Control operations are issued only while no sample is in flight, so each parameter change is clearly before or after a given sample, matching the next-sample rule.

// File: rtl/echo_pkg.sv
// Shared encodings for the echo delay line.
// Assumes: the control op field is two bits wide.
package echo_pkg;
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_INC  = 2'd2,
        OP_DEC  = 2'd3
    } ctl_op_e;

    localparam logic SEL_DELAY = 1'b0;
    localparam logic SEL_GAIN  = 1'b1;
endpackage

// File: rtl/echo_param_reg.sv
// Saturating parameter register: load / increment / decrement, clamped to [MIN, MAX].
// Assumes: MIN <= INIT <= MAX, and MAX fits in W bits.
module echo_param_reg
    import echo_pkg::*;
#(
    parameter int W    = 8,
    parameter int LW   = 16,
    parameter int MIN  = 1,
    parameter int MAX  = 255,
    parameter int STEP = 1,
    parameter int INIT = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [1:0]    op,
    input  logic [LW-1:0] load_val,
    output logic [W-1:0]  value
);
    localparam int XW = ((LW > W) ? LW : W) + 1;

    logic [XW-1:0] cur_x, load_x, up_x, next_x;

    // Compute the next stored value, clamping every operation to the range.
    always_comb begin
        cur_x  = XW'(value);
        load_x = XW'(load_val);
        up_x   = cur_x + XW'(STEP);
        next_x = cur_x;
        if (en) begin
            case (op)
                OP_LOAD: begin
                    if (load_x > XW'(MAX))      next_x = XW'(MAX);
                    else if (load_x < XW'(MIN)) next_x = XW'(MIN);
                    else                        next_x = load_x;
                end
                OP_INC:  next_x = (up_x > XW'(MAX)) ? XW'(MAX) : up_x;
                OP_DEC:  next_x = (cur_x < XW'(MIN) + XW'(STEP)) ? XW'(MIN)
                                                                  : cur_x - XW'(STEP);
                default: next_x = cur_x;
            endcase
        end
    end

    // Hold the parameter; reset to INIT.
    always_ff @(posedge clk) begin
        if (!rst_n) value <= W'(INIT);
        else        value <= next_x[W-1:0];
    end
endmodule

// File: rtl/echo_ring_ram.sv
// Simple dual-port buffer: one write port, one registered read port.
// Assumes: the same address is never written and read in one cycle (no bypass).
module echo_ring_ram #(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Write port: store one word per enabled cycle.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read port: registered output, as a block RAM provides.
    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/echo_fb_mix.sv
// Feedback mixer: y = sat(x + (g * d) >>> FRAC), with g unsigned and x, d signed.
// Assumes: FRAC < GW, and DW is at most 31.
module echo_fb_mix #(
    parameter int DW   = 16,
    parameter int GW   = 16,
    parameter int FRAC = 15
) (
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] d,
    input  logic [GW-1:0] g,
    output logic [DW-1:0] y
);
    localparam int PW = DW + GW + 1;
    localparam logic signed [PW-1:0] HI = PW'((64'sd1 <<< (DW - 1)) - 64'sd1);
    localparam logic signed [PW-1:0] LO = -HI - PW'(1);

    logic signed [PW-1:0] prod, scaled, x_ext, sum;

    // Scale the delayed sample, add the dry input and clamp to DW bits.
    always_comb begin
        prod   = PW'($signed(d)) * $signed({{(PW-GW){1'b0}}, g});
        scaled = prod >>> FRAC;
        x_ext  = PW'($signed(x));
        sum    = x_ext + scaled;
        if (sum > HI)      y = HI[DW-1:0];
        else if (sum < LO) y = LO[DW-1:0];
        else               y = sum[DW-1:0];
    end
endmodule

// File: rtl/echo_delay_line.sv
// Recirculating echo: out = sat(in + g * out[n - D]), and out is stored back into the ring.
// Assumes: in_valid pulses are separated by at least one idle cycle. Latency is two edges.
module echo_delay_line
    import echo_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 8,
    parameter int GAIN_W    = 16,
    parameter int GAIN_FRAC = 15,
    parameter int GAIN_CEIL = 'h7800,
    parameter int GAIN_STEP = 'h0400,
    parameter int CTL_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_sample,
    input  logic              ctl_en,
    input  logic              ctl_sel,
    input  logic [1:0]        ctl_op,
    input  logic [CTL_W-1:0]  ctl_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_sample,
    output logic [ADDR_W-1:0] cur_delay,
    output logic [GAIN_W-1:0] cur_gain
);
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int DELAY_MAX = DEPTH - 1;

    logic              delay_en, gain_en;
    logic [ADDR_W-1:0] wr_ptr, fill_cnt, rd_addr;
    logic              stage_v, primed_q;
    logic [DATA_W-1:0] x_q, rd_data, delayed, mix_y;

    assign delay_en = ctl_en && (ctl_sel == SEL_DELAY);
    assign gain_en  = ctl_en && (ctl_sel == SEL_GAIN);

    echo_param_reg #(
        .W(ADDR_W), .LW(CTL_W), .MIN(1), .MAX(DELAY_MAX), .STEP(1), .INIT(1)
    ) u_delay_reg (
        .clk(clk), .rst_n(rst_n), .en(delay_en), .op(ctl_op),
        .load_val(ctl_data), .value(cur_delay)
    );

    echo_param_reg #(
        .W(GAIN_W), .LW(CTL_W), .MIN(0), .MAX(GAIN_CEIL), .STEP(GAIN_STEP), .INIT(0)
    ) u_gain_reg (
        .clk(clk), .rst_n(rst_n), .en(gain_en), .op(ctl_op),
        .load_val(ctl_data), .value(cur_gain)
    );

    // The read tap trails the write pointer by the programmed delay, wrapping around the ring.
    assign rd_addr = wr_ptr - cur_delay;

    echo_ring_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ring (
        .clk(clk),
        .we(stage_v), .waddr(wr_ptr), .wdata(mix_y),
        .re(in_valid), .raddr(rd_addr), .rdata(rd_data)
    );

    // A slot that has never been written reads as silence.
    assign delayed = primed_q ? rd_data : '0;

    echo_fb_mix #(.DW(DATA_W), .GW(GAIN_W), .FRAC(GAIN_FRAC)) u_mix (
        .x(x_q), .d(delayed), .g(cur_gain), .y(mix_y)
    );

    // Stage 1: capture the sample and check that the tap points at written data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_v  <= 1'b0;
            x_q      <= '0;
            primed_q <= 1'b0;
        end else begin
            stage_v <= in_valid;
            if (in_valid) begin
                x_q      <= in_sample;
                primed_q <= (fill_cnt >= cur_delay);
            end
        end
    end

    // Stage 2: advance the pointer and the fill count after each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            fill_cnt <= '0;
        end else if (stage_v) begin
            wr_ptr <= wr_ptr + 1'b1;
            if (fill_cnt != ADDR_W'(DELAY_MAX)) fill_cnt <= fill_cnt + 1'b1;
        end
    end

    // Output register: present the mixed sample for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= stage_v;
            if (stage_v) out_sample <= mix_y;
        end
    end
endmodule

// File: rtl/echo_delay_line_chk.sv
// Property checker bound to echo_delay_line. It watches only the ports.
// Assumes: sample strobes are at least one idle cycle apart.
module echo_delay_line_chk #(
    parameter int ADDR_W    = 8,
    parameter int GAIN_W    = 16,
    parameter int GAIN_CEIL = 'h7800,
    parameter int CTL_W     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              ctl_en,
    input logic              ctl_sel,
    input logic [1:0]        ctl_op,
    input logic [CTL_W-1:0]  ctl_data,
    input logic              out_valid,
    input logic [ADDR_W-1:0] cur_delay,
    input logic [GAIN_W-1:0] cur_gain
);
    // R2: input assumption, no back-to-back sample strobes
    assert_sample_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> !in_valid);

    // R2: every sample produces an output two edges later
    assert_out_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    // R2: no output in the cycle right after a sample strobe
    assert_out_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> !out_valid);

    // R6: the gain never exceeds its ceiling
    assert_gain_ceiling_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cur_gain <= GAIN_W'(GAIN_CEIL));

    // R6: an increment at the ceiling holds the ceiling
    assert_gain_inc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_en && ctl_sel && ctl_op == 2'd2 && cur_gain == GAIN_W'(GAIN_CEIL))
        |=> cur_gain == GAIN_W'(GAIN_CEIL));

    // R7: the delay never reaches zero
    assert_delay_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cur_delay != '0);

    // R8: the delay changes only under a delay-select control operation
    assert_delay_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_en && !ctl_sel && ctl_op != 2'd0) |=> $stable(cur_delay));
endmodule

bind echo_delay_line echo_delay_line_chk #(
    .ADDR_W(ADDR_W), .GAIN_W(GAIN_W), .GAIN_CEIL(GAIN_CEIL), .CTL_W(CTL_W)
) u_chk (.*);

// File: tb/echo_delay_line_bench.sv
// Scoreboard bench: the driver pushes model results, and the monitor pops them at each output strobe.
module echo_delay_line_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH_MAX  = 255;
    localparam int CEIL       = 'h7800;
    localparam int GSTEP      = 'h0400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = '0;
    logic        ctl_en = 1'b0;
    logic        ctl_sel = 1'b0;
    logic [1:0]  ctl_op = '0;
    logic [15:0] ctl_data = '0;
    logic        out_valid;
    logic [15:0] out_sample;
    logic [7:0]  cur_delay;
    logic [15:0] cur_gain;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int    exp_q[$];
    string tag_q[$];
    int    hist[0:4095];
    int    n_samp = 0;
    int    m_delay = 1;
    int    m_gain = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    echo_delay_line u_echo_delay_line (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .ctl_en(ctl_en), .ctl_sel(ctl_sel), .ctl_op(ctl_op), .ctl_data(ctl_data),
        .out_valid(out_valid), .out_sample(out_sample),
        .cur_delay(cur_delay), .cur_gain(cur_gain)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int clampi(input int v, input int lo, input int hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    // Driver: compute the expected output from the requirements, then strobe one sample.
    task automatic send(input int x, input string tag);
        int d, p, y;
        d = (n_samp >= m_delay) ? hist[n_samp - m_delay] : 0;
        p = (m_gain * d) >>> 15;
        y = clampi(x + p, -32768, 32767);
        hist[n_samp] = y;
        n_samp++;
        exp_q.push_back(y);
        tag_q.push_back(tag);
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = 16'(x);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b0, "R2 gap", int'(out_valid), 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R2 latency", int'(out_valid), 1);
    endtask

    // Control driver: apply one operation and check the register against the model.
    task automatic ctl(input bit sel, input int op, input int data, input string tag);
        int cur, lo, hi, st;
        cur = sel ? m_gain : m_delay;
        lo  = sel ? 0 : 1;
        hi  = sel ? CEIL : DEPTH_MAX;
        st  = sel ? GSTEP : 1;
        case (op)
            1: cur = clampi(data, lo, hi);
            2: cur = clampi(cur + st, lo, hi);
            3: cur = clampi(cur - st, lo, hi);
            default: ;
        endcase
        if (sel) m_gain = cur; else m_delay = cur;
        @(negedge clk);
        ctl_en = 1'b1; ctl_sel = sel; ctl_op = 2'(op); ctl_data = 16'(data);
        @(negedge clk);
        ctl_en = 1'b0; ctl_op = 2'd0;
        if (sel) check(int'(cur_gain) == m_gain, tag, int'(cur_gain), m_gain);
        else     check(int'(cur_delay) == m_delay, tag, int'(cur_delay), m_delay);
    endtask

    // Monitor: compare each output strobe with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected output", int'($signed(out_sample)), 0);
            end else begin
                int e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(int'($signed(out_sample)) == e, t, int'($signed(out_sample)), e);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R2 watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(out_sample == 16'd0, "R1 out_sample", int'(out_sample), 0);
        check(cur_delay == 8'd1, "R1 delay", int'(cur_delay), 1);
        check(cur_gain == 16'd0, "R1 gain", int'(cur_gain), 0);

        // R9: gain 0 passes the input straight through
        send(1234, "R9 dry");
        send(-20000, "R9 dry");
        send(32767, "R9 dry");

        // R4: impulse echoes at spacing 4 with gain 0.5
        ctl(1'b0, 1, 4, "R7 delay load");
        ctl(1'b1, 1, 'h4000, "R7 gain load");
        send(1000, "R4 impulse");
        for (int i = 0; i < 10; i++) send(0, "R4 echo tail");
        send(-777, "R3 mix");
        send(555, "R3 mix");

        // R6: clamp on load and on increment
        ctl(1'b1, 1, 'hFFFF, "R6 load clamp");
        ctl(1'b1, 2, 0, "R6 inc at ceiling");
        ctl(1'b1, 3, 0, "R7 gain dec");
        ctl(1'b1, 2, 0, "R6 inc back to ceiling");

        // R5: saturation in both directions at spacing 1
        ctl(1'b0, 1, 1, "R7 delay load");
        send(30000, "R5 pos");
        send(30000, "R5 pos sat");
        send(-32768, "R5 neg");
        send(-30000, "R5 neg sat");
        send(-30000, "R5 neg sat");

        // R8: change delay mid-stream; old buffer contents stay in use
        ctl(1'b0, 1, 6, "R8 delay change");
        send(0, "R8 after change");
        send(100, "R8 after change");
        ctl(1'b0, 3, 0, "R8 delay dec");
        send(0, "R8 after dec");
        send(-50, "R8 after dec");

        // R7: delay range limits
        ctl(1'b0, 1, 0, "R7 delay load below min");
        ctl(1'b0, 3, 0, "R7 delay dec at min");
        ctl(1'b0, 1, 300, "R7 delay load above max");
        ctl(1'b0, 2, 0, "R7 delay inc at max");
        ctl(1'b1, 1, 0, "R7 gain load zero");
        ctl(1'b1, 3, 0, "R7 gain dec at min");
        send(42, "R3 long delay unprimed");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R2 outstanding", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule